// File: doc/BRIEF.md
# Interrupt Vector Status Encoder

This block forms the 8-bit interrupt vector that a processor reads, either during an interrupt acknowledge cycle or through a plain read of the status-capable channel's vector register. It starts from a programmed base vector. It can then overwrite a 3-bit field of that vector with a code. The code names the highest-priority source that currently has an interrupt pending. The field sits either in bits 1..3 or in bits 4..6, chosen by a select input.

The vector is live: between reads it follows the pending sources and the control inputs. While a read strobe is held, the value on the output is frozen. A higher-priority request that arrives in the middle of a read therefore cannot corrupt the byte being returned. The block also produces a data-bus drive enable. During an acknowledge cycle this enable honours a no-vector control. On a status-channel read it is always asserted. Arbitration between chips and clearing of the sources belong to other blocks.

Top module: `irq_vector_encoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `vec_out` becomes 8'h00 and `bus_drive` becomes 0 after that edge.
- R2: Pending bit 0 has the highest priority. The status code is the index of the lowest-numbered set bit of `pend`. When `pend` is all zero the code is 3'b111.
- R3: When status is included, `stat_hi`=1 places the code in bits 6:4 and `stat_hi`=0 places it in bits 3:1. Code bit 0 goes to the lowest bit of the field. Every bit outside the field equals the same bit of `base_vec`.
- R4: With `vis_en`=0 and not (`ack`=0 and `sts_chan`=1), the vector equals `base_vec` unchanged.
- R5: With `ack`=0 and `sts_chan`=1, the vector always includes the status code, whatever `vis_en` is.
- R6: On a read that starts with `ack`=1, `bus_drive` is 1 for the read when `no_vec`=0 and 0 when `no_vec`=1.
- R7: On a read that starts with `ack`=0, `bus_drive` is 1 when `sts_chan`=1 and 0 when `sts_chan`=0.
- R8: While no read is held (`rd` was 0 at the previous edge), `vec_out` after each edge reflects the inputs sampled at that edge.
- R9: The value captured at the first edge where `rd`=1 stays on `vec_out`, unchanged, for as long as `rd` stays 1. The same holds for the `bus_drive` decision.
- R10: `bus_drive` is 0 after any edge at which `rd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_vec | input | 8 | Programmed base vector |
| pend | input | 6 | Pending flags, bit 0 highest priority |
| vis_en | input | 1 | Include status code in the vector |
| stat_hi | input | 1 | 1: code in bits 6:4, 0: code in bits 3:1 |
| no_vec | input | 1 | Suppress bus drive during acknowledge |
| ack | input | 1 | Interrupt acknowledge cycle in progress |
| rd | input | 1 | Read strobe, active high |
| sts_chan | input | 1 | Read targets the status-capable channel |
| vec_out | output | 8 | Vector byte (live, frozen during a read) |
| bus_drive | output | 1 | Data bus drive enable |

## Verification
A faulty hold register shows up on `vec_out` at the second cycle of a read in which `pend` changes. The frozen byte would then move, and the bench flags it one edge after the change. A wrong priority chain or field placement corrupts `vec_out` one edge after the offending `pend` or `stat_hi` pattern is applied. The random phase makes that visible within a few cycles. A stale drive decision appears on `bus_drive` in the first cycle of a read, or in the cycle after `rd` falls.

// File: rtl/ivse_pkg.sv
package ivse_pkg;

    localparam int VEC_W  = 8;
    localparam int CODE_W = 3;

    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        ACC_ACK   = 2'd0,
        ACC_STS   = 2'd1,
        ACC_OTHER = 2'd2
    } acc_kind_e;

    typedef struct packed {
        vec_t vec;
        logic drive;
    } rd_word_t;

    function automatic acc_kind_e classify(input logic ack, input logic sts_chan);
        if (ack)           return ACC_ACK;
        else if (sts_chan) return ACC_STS;
        else               return ACC_OTHER;
    endfunction

    function automatic vec_t field_mask(input int pos);
        vec_t m;
        m = '0;
        for (int i = 0; i < CODE_W; i++) m[pos + i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ivse_prio_enc.sv
module ivse_prio_enc
    import ivse_pkg::*;
#(
    parameter int    NSRC      = 6,
    parameter code_t NONE_CODE = 3'b111
) (
    input  logic [NSRC-1:0] pend,
    output code_t           code
);
    logic [NSRC:0]   blocked;
    logic [NSRC-1:0] win;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign win[i]       = pend[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | pend[i];
    end

    always_comb begin
        code = NONE_CODE;
        for (int i = 0; i < NSRC; i++)
            if (win[i]) code = code_t'(i);
    end

    // R2: the none-pending code appears exactly when nothing is pending
    always_comb begin
        p_none_code_r2: assert ((code == NONE_CODE) == (pend == '0))
            else $error("p_none_code_r2");
    end

endmodule

// File: rtl/ivse_merge.sv
module ivse_merge
    import ivse_pkg::*;
#(
    parameter int LO_POS = 1,
    parameter int HI_POS = 4
) (
    input  vec_t  base,
    input  code_t code,
    input  logic  incl,
    input  logic  stat_hi,
    output vec_t  merged
);
    for (genvar b = 0; b < VEC_W; b++) begin : g_bit
        localparam bit IN_LO  = (b >= LO_POS) && (b < LO_POS + CODE_W);
        localparam bit IN_HI  = (b >= HI_POS) && (b < HI_POS + CODE_W);
        localparam int OFF_LO = IN_LO ? b - LO_POS : 0;
        localparam int OFF_HI = IN_HI ? b - HI_POS : 0;
        always_comb begin
            if (incl && IN_HI && stat_hi)       merged[b] = code[OFF_HI];
            else if (incl && IN_LO && !stat_hi) merged[b] = code[OFF_LO];
            else                                merged[b] = base[b];
        end
    end

    // R3: bits outside the selected field keep the base value
    vec_t sel_mask;
    assign sel_mask = incl ? field_mask(stat_hi ? HI_POS : LO_POS) : '0;
    always_comb begin
        p_outside_field_r3: assert ((merged & ~sel_mask) == (base & ~sel_mask))
            else $error("p_outside_field_r3");
    end

endmodule

// File: rtl/ivse_hold.sv
module ivse_hold
    import ivse_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rd,
    input  rd_word_t live,
    output rd_word_t held
);
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            held <= '0;
        end else begin
            rd_q <= rd;
            if (!rd_q) held.vec <= live.vec;
            if (!rd)       held.drive <= 1'b0;
            else if (!rd_q) held.drive <= live.drive;
        end
    end

    // R9: once a read is under way the captured byte does not move
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_q && rd) |=> $stable(held))
        else $error("p_hold_stable_r9");

    // R10: drive enable is released after the strobe is gone
    p_drive_drop_r10: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !held.drive)
        else $error("p_drive_drop_r10");

endmodule

// File: rtl/irq_vector_encoder.sv
module irq_vector_encoder
    import ivse_pkg::*;
#(
    parameter int    NSRC      = 6,
    parameter int    LO_POS    = 1,
    parameter int    HI_POS    = 4,
    parameter code_t NONE_CODE = 3'b111
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [7:0]      base_vec,
    input  logic [NSRC-1:0] pend,
    input  logic            vis_en,
    input  logic            stat_hi,
    input  logic            no_vec,
    input  logic            ack,
    input  logic            rd,
    input  logic            sts_chan,
    output logic [7:0]      vec_out,
    output logic            bus_drive
);
    acc_kind_e kind;
    code_t     code;
    logic      incl;
    vec_t      merged;
    rd_word_t  live, held;

    assign kind = classify(ack, sts_chan);
    assign incl = vis_en | (kind == ACC_STS);

    ivse_prio_enc #(.NSRC(NSRC), .NONE_CODE(NONE_CODE)) u_prio (
        .pend (pend),
        .code (code)
    );

    ivse_merge #(.LO_POS(LO_POS), .HI_POS(HI_POS)) u_merge (
        .base    (base_vec),
        .code    (code),
        .incl    (incl),
        .stat_hi (stat_hi),
        .merged  (merged)
    );

    always_comb begin
        live.vec = merged;
        unique case (kind)
            ACC_ACK: live.drive = !no_vec;
            ACC_STS: live.drive = 1'b1;
            default: live.drive = 1'b0;
        endcase
    end

    ivse_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .rd   (rd),
        .live (live),
        .held (held)
    );

    assign vec_out   = held.vec;
    assign bus_drive = held.drive;

    // R6: acknowledge read with vector suppressed never drives the bus
    p_no_vector_r6: assert property (@(posedge clk) disable iff (rst)
        (rd && !$past(rd) && ack && no_vec) |=> !bus_drive)
        else $error("p_no_vector_r6");

    // R7: a read that is neither acknowledge nor status channel never drives
    p_other_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd && !$past(rd) && !ack && !sts_chan) |=> !bus_drive)
        else $error("p_other_read_r7");

endmodule

// File: tb/test_irq_vector_encoder.sv
`timescale 1ns/1ps
module test_irq_vector_encoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] base_vec = '0;
    logic [5:0] pend = '0;
    logic       vis_en = 0, stat_hi = 0, no_vec = 0, ack = 0, rd = 0, sts_chan = 0;
    logic [7:0] vec_out;
    logic       bus_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_vec;
    logic       m_drv;
    logic       m_rdq;
    string      m_tag;
    string      phase;

    always #2.5 clk = ~clk;

    irq_vector_encoder i_irq_vector_encoder (
        .clk(clk), .rst(rst), .base_vec(base_vec), .pend(pend),
        .vis_en(vis_en), .stat_hi(stat_hi), .no_vec(no_vec), .ack(ack),
        .rd(rd), .sts_chan(sts_chan), .vec_out(vec_out), .bus_drive(bus_drive)
    );

    // R2: lowest set index wins, 7 when nothing pending
    function automatic logic [2:0] f_code(input logic [5:0] p);
        for (int i = 0; i < 6; i++) if (p[i]) return 3'(i);
        return 3'b111;
    endfunction

    // R3, R4, R5: field placement and inclusion rule
    function automatic logic [7:0] f_vec(input logic [7:0] b, input logic [5:0] p,
                                         input logic v, input logic h,
                                         input logic a, input logic s);
        logic [7:0] r;
        logic [2:0] c;
        r = b;
        c = f_code(p);
        if (v || (!a && s)) begin
            if (h) r[6:4] = c;
            else   r[3:1] = c;
        end
        return r;
    endfunction

    // R6, R7: drive decision at the start of a read
    function automatic logic f_drv(input logic a, input logic s, input logic nv);
        return a ? !nv : s;
    endfunction

    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_vec = 8'h00; m_drv = 1'b0; m_rdq = 1'b0; m_tag = "R1";
        end else begin
            m_tag = (m_rdq && rd) ? "R9" : phase;
            if (!m_rdq) m_vec = f_vec(base_vec, pend, vis_en, stat_hi, ack, sts_chan);
            if (!rd)        begin m_drv = 1'b0; if (m_rdq) m_tag = "R10"; end
            else if (!m_rdq) m_drv = f_drv(ack, sts_chan, no_vec);
            m_rdq = rd;
        end
        @(negedge clk);
        checks++;
        if (vec_out !== m_vec || bus_drive !== m_drv) begin
            errors++;
            $display("FAIL %s: vec_out=%h bus_drive=%b expected vec_out=%h bus_drive=%b",
                     m_tag, vec_out, bus_drive, m_vec, m_drv);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'h1d5e);
        @(negedge clk);
        phase = "R1"; rst = 1; step();
        rst = 0;
        // R2 low field, several pending
        phase = "R2"; vis_en = 1; stat_hi = 0; base_vec = 8'h00; pend = 6'b101100; step();
        // R2 none pending
        pend = 6'b000000; step();
        // R3 high field, ones around it
        phase = "R3"; stat_hi = 1; base_vec = 8'hFF; pend = 6'b100000; step();
        phase = "R3"; stat_hi = 0; base_vec = 8'h81; pend = 6'b000010; step();
        // R4 no status
        phase = "R4"; vis_en = 0; ack = 0; sts_chan = 0; base_vec = 8'hA5; pend = 6'b000001; step();
        // R5 status channel read ignores vis_en
        phase = "R5"; sts_chan = 1; rd = 1; pend = 6'b001000; step();
        // R9 freeze while higher priority arrives
        phase = "R9"; pend = 6'b000001; step(); step();
        // R10 strobe released
        phase = "R10"; rd = 0; step();
        phase = "R8"; step();
        // R6 acknowledge with vector suppressed, then allowed
        phase = "R6"; ack = 1; no_vec = 1; vis_en = 1; rd = 1; step(); step();
        rd = 0; step();
        no_vec = 0; rd = 1; step(); step();
        rd = 0; step();
        // R7 ordinary read of the other channel
        phase = "R7"; ack = 0; sts_chan = 0; rd = 1; step(); step();
        rd = 0; step();
        // R8/R9 random
        for (int n = 0; n < 4000; n++) begin
            phase = "R8";
            base_vec = 8'($urandom);
            pend     = 6'($urandom) & ((($urandom % 4) == 0) ? 6'h00 : 6'h3F);
            vis_en   = 1'($urandom);
            stat_hi  = 1'($urandom);
            no_vec   = 1'($urandom);
            ack      = 1'($urandom);
            sts_chan = 1'($urandom);
            if (($urandom % 3) == 0) rd = ~rd;
            if (($urandom % 97) == 0) begin phase = "R1"; rst = 1; end
            step();
            rst = 0;
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule